// File: doc/BRIEF.md
# Branch and next-PC resolution unit

This block keeps the program counter pair of an integer core with one branch delay slot: `pc_o` addresses the instruction now being resolved, and `npc_o` the one after it. Each cycle the instruction fetched at `pc_o` arrives on `instr_i` together with the four integer condition flags. The block works out whether control moves elsewhere and registers the next pair of PC values. Any transfer is delayed. The old next-PC becomes the PC, so the delay-slot instruction still runs, and the computed target is loaded into the next-PC.

Conditional branches are resolved through a sixteen-entry condition table. Calls and branches get PC-relative targets. A register-indirect jump takes its target from the datapath on `jtgt_i`. When the branch's annul bit requests it, the delay-slot instruction is squashed: `annul_o` is high for the cycle in which that instruction is presented, and the block ignores it during that cycle. A call also raises a link-write request that carries its own address.

Top module: `brn_npc_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets `pc_o` to 0, `npc_o` to 4 and `annul_o` to 0.
- R2: An instruction that transfers no control advances the pair: `pc_o` takes the old `npc_o` and `npc_o` becomes the old `npc_o` plus 4. Instructions of this kind are: op field `instr_i[31:30]` = 10 or 11 other than the jump, and op = 00 with `instr_i[24:22]` other than 010 (this includes sethi, 100).
- R3: A conditional branch (op = 00, `instr_i[24:22]` = 010) that is taken loads `pc_o` with the old `npc_o` and `npc_o` with `pc_o` + (sign-extended `instr_i[21:0]` << 2). An untaken branch advances as in R2.
- R4: The condition `instr_i[28:25]` is evaluated on `flags_i` = {N,Z,V,C} (bit 3 = N, bit 0 = C). The low three bits select: 000 never, 001 Z, 010 Z|(N^V), 011 N^V, 100 C|Z, 101 C, 110 N, 111 V. Bit 3 set inverts the result.
- R5: `annul_o` is set for the next cycle when the branch has its annul bit `instr_i[29]` set and is either untaken or has the always condition (1000). A taken branch with any other condition never sets it.
- R6: While `annul_o` is high, `instr_i` is ignored. The pair advances as in R2, and no link request, misalignment flag or annul is raised.
- R7: A call (op = 01) loads `pc_o` with the old `npc_o` and `npc_o` with `pc_o` + (`instr_i[29:0]` << 2), modulo 2^32.
- R8: In the same cycle as a call, `link_we_o` is 1, `link_rd_o` is 15 and `link_val_o` equals `pc_o`. Otherwise `link_we_o` is 0.
- R9: A jump (op = 10, `instr_i[24:19]` = 111000) loads `pc_o` with the old `npc_o` and `npc_o` with `jtgt_i`.
- R10: In the same cycle as a jump, `misalign_o` is 1 exactly when `jtgt_i[1:0]` is not 00. It is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_i | input | 32 | Instruction fetched at `pc_o` |
| flags_i | input | 4 | Condition flags {N,Z,V,C} |
| jtgt_i | input | 32 | Register-indirect jump target from the datapath |
| pc_o | output | 32 | Current PC |
| npc_o | output | 32 | Next PC |
| annul_o | output | 1 | Instruction at `pc_o` is squashed |
| link_we_o | output | 1 | Link register write request |
| link_rd_o | output | 5 | Link register index |
| link_val_o | output | 32 | Link value (address of the call) |
| misalign_o | output | 1 | Jump target not word aligned |

## Verification
The link request and the misalignment flag are combinational, so they are due in the same cycle as the instruction. The bench reads them one nanosecond after driving the inputs on the falling edge. `pc_o`, `npc_o` and `annul_o` pass through one register and are due after the next rising edge. The bench reads them at the following falling edge and compares them with a model that is advanced once per instruction. The annul squash covers two cycles: it is set by the branch and takes effect on the instruction presented next. For that reason, a call is placed in the squashed slot and the bench confirms that this call produces no link request and no transfer.

// File: rtl/brn_pkg.sv
package brn_pkg;

    // Major instruction classes, from the two top bits
    typedef enum logic [1:0] {
        OP_BRANCH = 2'b00,
        OP_CALL   = 2'b01,
        OP_ALU    = 2'b10,
        OP_MEM    = 2'b11
    } op_class_e;

    localparam logic [2:0] OP2_ICC_BRANCH = 3'b010;
    localparam logic [5:0] OP3_JUMP_LINK  = 6'b111000;
    localparam logic [3:0] COND_ALWAYS    = 4'b1000;

    // Flag positions in the packed flag vector {N,Z,V,C}
    localparam int FLAG_N = 3;
    localparam int FLAG_Z = 2;
    localparam int FLAG_V = 1;
    localparam int FLAG_C = 0;

endpackage

// File: rtl/brn_cond.sv
module brn_cond
    import brn_pkg::*;
(
    input  logic [3:0] cond_i,
    input  logic [3:0] flags_i,
    output logic       taken_o
);
    logic n, z, v, c;
    logic base;

    assign n = flags_i[FLAG_N];
    assign z = flags_i[FLAG_Z];
    assign v = flags_i[FLAG_V];
    assign c = flags_i[FLAG_C];

    always_comb begin
        unique case (cond_i[2:0])
            3'd0:    base = 1'b0;
            3'd1:    base = z;
            3'd2:    base = z | (n ^ v);
            3'd3:    base = n ^ v;
            3'd4:    base = c | z;
            3'd5:    base = c;
            3'd6:    base = n;
            default: base = v;
        endcase
    end

    // Upper half of the table is the complement of the lower half
    assign taken_o = base ^ cond_i[3];

endmodule

// File: rtl/brn_decode.sv
module brn_decode
    import brn_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int INS_W = 32
) (
    input  logic [INS_W-1:0] instr_i,
    input  logic [PC_W-1:0]  pc_i,
    input  logic [PC_W-1:0]  jtgt_i,
    output logic             is_bcc_o,
    output logic             is_call_o,
    output logic             is_jump_o,
    output logic             abit_o,
    output logic [3:0]       cond_o,
    output logic [PC_W-1:0]  tgt_o
);
    localparam int BDISP_W = 22;
    localparam int CDISP_W = 30;
    localparam int WSHIFT  = 2;

    op_class_e           op;
    logic [PC_W-1:0]     boff;
    logic [PC_W-1:0]     coff;

    assign op        = op_class_e'(instr_i[INS_W-1 -: 2]);
    assign is_bcc_o  = (op == OP_BRANCH) && (instr_i[24:22] == OP2_ICC_BRANCH);
    assign is_call_o = (op == OP_CALL);
    assign is_jump_o = (op == OP_ALU) && (instr_i[24:19] == OP3_JUMP_LINK);
    assign abit_o    = instr_i[29];
    assign cond_o    = instr_i[28:25];

    // Word displacements scaled to bytes; branch one sign-extended
    assign boff = PC_W'({{(PC_W-BDISP_W-WSHIFT){instr_i[BDISP_W-1]}},
                         instr_i[BDISP_W-1:0], {WSHIFT{1'b0}}});
    assign coff = PC_W'({instr_i[CDISP_W-1:0], {WSHIFT{1'b0}}});

    always_comb begin
        if (is_jump_o)      tgt_o = jtgt_i;
        else if (is_call_o) tgt_o = pc_i + coff;
        else                tgt_o = pc_i + boff;
    end

endmodule

// File: rtl/brn_npc_unit.sv
module brn_npc_unit
    import brn_pkg::*;
#(
    parameter int PC_W     = 32,
    parameter int REG_W    = 5,
    parameter int LINK_REG = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [31:0]      instr_i,
    input  logic [3:0]       flags_i,
    input  logic [PC_W-1:0]  jtgt_i,
    output logic [PC_W-1:0]  pc_o,
    output logic [PC_W-1:0]  npc_o,
    output logic             annul_o,
    output logic             link_we_o,
    output logic [REG_W-1:0] link_rd_o,
    output logic [PC_W-1:0]  link_val_o,
    output logic             misalign_o
);
    localparam logic [PC_W-1:0] STEP      = PC_W'(4);
    localparam logic [PC_W-1:0] RESET_PC  = '0;

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic [PC_W-1:0] npc;
        logic            annul;
    } seq_t;

    seq_t seq_d, seq_q;

    logic            is_bcc, is_call, is_jump, abit, taken;
    logic [3:0]      cond;
    logic [PC_W-1:0] tgt;
    logic            xfer;

    brn_decode #(.PC_W(PC_W), .INS_W(32)) u_dec (
        .instr_i   (instr_i),
        .pc_i      (seq_q.pc),
        .jtgt_i    (jtgt_i),
        .is_bcc_o  (is_bcc),
        .is_call_o (is_call),
        .is_jump_o (is_jump),
        .abit_o    (abit),
        .cond_o    (cond),
        .tgt_o     (tgt)
    );

    brn_cond u_cond (
        .cond_i  (cond),
        .flags_i (flags_i),
        .taken_o (taken)
    );

    assign xfer = (is_bcc & taken) | is_call | is_jump;

    always_comb begin
        seq_d.pc    = seq_q.npc;
        seq_d.npc   = seq_q.npc + STEP;
        seq_d.annul = 1'b0;
        link_we_o   = 1'b0;
        misalign_o  = 1'b0;
        if (!seq_q.annul) begin
            if (xfer) seq_d.npc = tgt;
            if (is_bcc) seq_d.annul = abit & (~taken | (cond == COND_ALWAYS));
            link_we_o  = is_call;
            misalign_o = is_jump & (|tgt[1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q.pc    <= RESET_PC;
            seq_q.npc   <= RESET_PC + STEP;
            seq_q.annul <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign pc_o       = seq_q.pc;
    assign npc_o      = seq_q.npc;
    assign annul_o    = seq_q.annul;
    assign link_rd_o  = REG_W'(LINK_REG);
    assign link_val_o = seq_q.pc;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (pc_o == RESET_PC && npc_o == STEP && !annul_o));

    // R2
    seq_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (!annul_o && !xfer) |=> (pc_o == $past(npc_o) && npc_o == $past(npc_o) + STEP));

    // R6
    annul_skip_chk: assert property (@(posedge clk) disable iff (rst)
        annul_o |=> (npc_o == $past(npc_o) + STEP && !annul_o));

    // R5
    taken_keeps_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (!annul_o && is_bcc && taken && cond != COND_ALWAYS) |=> !annul_o);

    // R7
    call_target_chk: assert property (@(posedge clk) disable iff (rst)
        link_we_o |=> (npc_o == $past(pc_o) + PC_W'({$past(instr_i[29:0]), 2'b00})));

    // R9
    jump_target_chk: assert property (@(posedge clk) disable iff (rst)
        (!annul_o && is_jump) |=> (npc_o == $past(jtgt_i) && pc_o == $past(npc_o)));

    // R10
    misalign_only_jump_chk: assert property (@(posedge clk) disable iff (rst)
        misalign_o |-> (instr_i[31:30] == 2'b10 && jtgt_i[1:0] != 2'b00));

endmodule

// File: tb/sim_brn_npc_unit.sv
`timescale 1ns/1ps
module sim_brn_npc_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr = 32'h8000_0000;
    logic [3:0]  flags = 4'h0;
    logic [31:0] jtgt  = 32'h0;
    logic [31:0] pc_o, npc_o, link_val_o;
    logic        annul_o, link_we_o, misalign_o;
    logic [4:0]  link_rd_o;

    int n_chk  = 0;
    int n_fail = 0;
    logic [31:0] e_pc, e_npc;
    logic        e_an;

    always #2.5 clk = ~clk;

    brn_npc_unit u0 (
        .clk(clk), .rst(rst), .instr_i(instr), .flags_i(flags), .jtgt_i(jtgt),
        .pc_o(pc_o), .npc_o(npc_o), .annul_o(annul_o), .link_we_o(link_we_o),
        .link_rd_o(link_rd_o), .link_val_o(link_val_o), .misalign_o(misalign_o)
    );

    localparam logic [31:0] NOP = 32'h8000_0000;

    function automatic logic [31:0] bcc(input logic a, input logic [3:0] c, input logic [21:0] d);
        return {2'b00, a, c, 3'b010, d};
    endfunction

    function automatic logic [31:0] call(input logic [29:0] d);
        return {2'b01, d};
    endfunction

    function automatic logic [31:0] jump();
        return {2'b10, 5'd15, 6'b111000, 19'd0};
    endfunction

    // Condition table taken from R4
    function automatic logic cond_ok(input logic [3:0] c, input logic [3:0] f);
        logic n, z, v, cy, r;
        n = f[3]; z = f[2]; v = f[1]; cy = f[0];
        case (c[2:0])
            3'd0: r = 1'b0;
            3'd1: r = z;
            3'd2: r = z | (n ^ v);
            3'd3: r = n ^ v;
            3'd4: r = cy | z;
            3'd5: r = cy;
            3'd6: r = n;
            default: r = v;
        endcase
        return r ^ c[3];
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Present one instruction, check same-cycle outputs, then the registered pair
    task automatic step(input logic [31:0] ins, input logic [3:0] fl, input logic [31:0] tg, input string tag);
        logic tk, xf, ea, lw, mis;
        logic [31:0] t;
        instr = ins; flags = fl; jtgt = tg;
        #1;
        xf = 0; ea = 0; lw = 0; mis = 0; t = 0;
        if (!e_an) begin
            case (ins[31:30])
                2'b00: if (ins[24:22] == 3'b010) begin
                    tk = cond_ok(ins[28:25], fl);
                    t  = e_pc + {{8{ins[21]}}, ins[21:0], 2'b00};
                    xf = tk;
                    ea = ins[29] & (!tk || ins[28:25] == 4'b1000);
                end
                2'b01: begin xf = 1; t = e_pc + {ins[29:0], 2'b00}; lw = 1; end
                2'b10: if (ins[24:19] == 6'b111000) begin
                    xf = 1; t = tg; mis = (tg[1:0] != 2'b00);
                end
                default: ;
            endcase
        end
        chk(link_we_o == lw && (!lw || (link_rd_o == 5'd15 && link_val_o == e_pc)),
            {tag, " link (R8)"}, {link_we_o, link_rd_o, link_val_o}, {lw, 5'd15, e_pc});
        chk(misalign_o == mis, {tag, " misalign (R10)"}, 96'(misalign_o), 96'(mis));
        e_pc  = e_npc;
        e_npc = xf ? t : e_npc + 32'd4;
        e_an  = ea;
        @(negedge clk);
        chk(pc_o == e_pc && npc_o == e_npc && annul_o == e_an, {tag, " pc/npc/annul"},
            {pc_o, npc_o, 31'd0, annul_o}, {e_pc, e_npc, 31'd0, e_an});
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        e_pc = 0; e_npc = 4; e_an = 0;
        chk(pc_o == 0 && npc_o == 4 && !annul_o && !link_we_o, "R1 reset",
            {pc_o, npc_o, 32'(annul_o)}, {32'd0, 32'd4, 32'd0});
    endtask

    task automatic t_seq();
        step(NOP, 4'hF, 0, "R2 alu");
        step(32'hD007_BFEC, 4'h0, 0, "R2 load");
        step({2'b00, 5'd1, 3'b100, 22'h3ABCD}, 4'h0, 0, "R2 sethi");
        step({2'b00, 1'b1, 4'b1000, 3'b110, 22'd8}, 4'h0, 0, "R2 other op2");
        step({2'b10, 5'd1, 6'b111001, 19'd0}, 4'h0, 32'h3, "R2 near-jump op3");
    endtask

    task automatic t_cond();
        logic [3:0] pats [6] = '{4'b0000, 4'b0100, 4'b1000, 4'b0001, 4'b0010, 4'b1010};
        for (int c = 0; c < 16; c++) begin
            for (int p = 0; p < 6; p++) begin
                step(bcc(1'b0, 4'(c), 22'd6), pats[p], 0, "R3/R4 branch fwd");
                step(NOP, 4'h0, 0, "R3 delay slot");
            end
        end
        step(bcc(1'b0, 4'b1000, 22'h3FFFFE), 4'h0, 0, "R3 branch back");
        step(NOP, 4'h0, 0, "R3 delay slot back");
    endtask

    task automatic t_annul();
        step(bcc(1'b1, 4'b1000, 22'd16), 4'h0, 0, "R5 always annul");
        step(call(30'd100), 4'h0, 0, "R6 squashed call");
        step(bcc(1'b1, 4'b0000, 22'd16), 4'h0, 0, "R5 never annul");
        step(jump(), 4'h0, 32'h1001, "R6 squashed jump");
        step(bcc(1'b1, 4'b1001, 22'd4), 4'h0, 0, "R5 taken ne annul");
        step(NOP, 4'h0, 0, "R5 kept slot");
        step(bcc(1'b1, 4'b1001, 22'd4), 4'h4, 0, "R5 untaken ne annul");
        step(bcc(1'b1, 4'b1000, 22'd4), 4'h0, 0, "R6 squashed branch");
        step(bcc(1'b0, 4'b0001, 22'd4), 4'h0, 0, "R5 untaken no abit");
    endtask

    task automatic t_call();
        step(call(30'd5), 4'h0, 0, "R7 call fwd");
        step(NOP, 4'h0, 0, "R7 slot");
        step(call(30'h3FFF_FFFC), 4'h0, 0, "R7 call wrap");
        step(NOP, 4'h0, 0, "R7 slot wrap");
    endtask

    task automatic t_jmpl();
        step(jump(), 4'h0, 32'h0000_2000, "R9 jump aligned");
        step(NOP, 4'h0, 0, "R9 slot");
        step(jump(), 4'h0, 32'h0000_3002, "R10 jump misaligned");
        step(NOP, 4'h0, 32'h1, "R10 no flag on alu");
        step(jump(), 4'h0, 32'h0000_0101, "R10 jump low bit");
        step(NOP, 4'h0, 0, "R9 slot 2");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_seq();
        t_cond();
        t_annul();
        t_call();
        t_jmpl();
        t_reset();
        step(NOP, 4'h0, 0, "R1 after mid-run reset");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule